// File: doc/BRIEF.md
# SPI Master Controller with Programmable Framing

This block is a serial peripheral interface master that empties a small byte queue onto the serial data output and gathers the bits returning on the serial data input into a second byte queue. Software talks to it through a word-addressed register port. A write at offset 0x00 queues a transmit byte taken from the low eight bits. A read at offset 0x04 with `reg_rd` high returns the oldest received byte and removes it. Offset 0x08 holds the control word. The serial clock runs at half the rate of an internal tick, and that tick comes from a fixed divider of `HALF_DIV` system clocks.

The control word sets four things: the level the serial clock rests at, the edge on which data is captured, the active level of the single chip select, and whether the least or the most significant bit goes first. A fifth setting chooses whether chip select stays asserted while queued bytes follow one another or is released after every byte. Two write-one bits empty the transmit queue and the receive queue. Neither bit ever reads back as 1. Queue status is shown on dedicated output pins.

Top module: `spi_master_ctl`

## Requirements
- R1: After reset, the control word reads 0x0012_001C. `cs` and `sclk` rest high, both queues are empty, and `rx_ovf` is 0.
- R2: While chip select is inactive, `sclk` rests at control bit 3 (0 means low, 1 means high).
- R3: With control bit 2 at 0, the first data bit is on `mosi` in the same cycle that chip select asserts. Data is captured on the leading clock edge, and `mosi` changes on the trailing edge.
- R4: With control bit 2 at 1, `mosi` changes on the leading clock edge and `miso` is captured on the trailing edge.
- R5: Control bit 6 at 0 sends and assembles bit 7 first. At 1, bit 0 goes first.
- R6: Control bit 4 at 0 makes chip select active high. At 1 it is active low. The idle level is the opposite of the active level.
- R7: With control bit 7 at 0, chip select stays asserted through every byte that is queued back to back. It is released once, after the transmit queue runs empty.
- R8: With control bit 7 at 1, chip select is released after each byte and stays inactive for at least one full SCLK period (2*HALF_DIV cycles) before the next byte.
- R9: Writing 1 to control bit 8 empties the transmit queue. Bit 8 always reads as 0.
- R10: Writing 1 to control bit 9 empties the receive queue and clears `rx_ovf`. Bit 9 always reads as 0.
- R11: A received byte that finds the receive queue full is discarded and sets `rx_ovf`, which stays set. The bytes already stored are unchanged.
- R12: A transmit write into a full queue is discarded.
- R13: A transfer starts only when control bit 0 (enable) and bit 1 (master select) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register byte offset (0x0, 0x4, 0x8) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Read strobe; pops the receive queue at 0x4 |
| reg_rdata | output | 32 | Register read data (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | 1 | Chip select, level set by control bit 4 |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_ovf | output | 1 | Sticky receive overflow |

## Verification
A wrong bit counter or edge selector appears within a single byte time, which is 16*HALF_DIV cycles. An external slave model then assembles a byte that differs from the one queued, or a byte that comes out reversed, and the byte read back from the receive queue no longer matches what the slave sent. A fault in the framing state shows on `cs`. The count of releases is wrong, or the inactive gap between bytes is shorter than one SCLK period, and both are measured in the cycle after the byte that follows. A fault in a queue pointer shows up at the next status sample or read: the flags are wrong, a byte goes missing or a byte appears twice.

// File: rtl/spi_master_ctl.sv
module spi_master_ctl #(
  parameter int HALF_DIV = 4,
  parameter int DEPTH    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  input  logic        reg_rd,
  output logic [31:0] reg_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs,
  output logic        tx_empty,
  output logic        tx_full,
  output logic        rx_empty,
  output logic        rx_full,
  output logic        rx_ovf
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [31:0] CTL_RST  = 32'h0012_001C;
  localparam logic [31:0] PULSE_MASK = 32'h0000_0300;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_TAIL, S_GAP} state_t;

  logic [31:0] ctl_q;
  logic en, master, cpha, cpol, cs_pol, lsb, cs_rel;
  logic wr_ctl, tx_clr, rx_clr, tx_push, tx_pop, rx_push, rx_pop;

  assign en     = ctl_q[0];
  assign master = ctl_q[1];
  assign cpha   = ctl_q[2];
  assign cpol   = ctl_q[3];
  assign cs_pol = ctl_q[4];
  assign lsb    = ctl_q[6];
  assign cs_rel = ctl_q[7];

  assign wr_ctl  = reg_wr && reg_addr == 4'h8;
  assign tx_clr  = wr_ctl && reg_wdata[8];
  assign rx_clr  = wr_ctl && reg_wdata[9];
  assign tx_push = reg_wr && reg_addr == 4'h0 && !tx_full;
  assign rx_pop  = reg_rd && reg_addr == 4'h4 && !rx_empty;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctl_q <= CTL_RST;
    else if (wr_ctl) ctl_q <= reg_wdata & ~PULSE_MASK;

  logic [7:0]  tx_mem [DEPTH];
  logic [AW:0] tx_wp, tx_rp;
  logic [7:0]  tx_head;

  assign tx_empty = tx_wp == tx_rp;
  assign tx_full  = (tx_wp - tx_rp) == FULL_CNT;
  assign tx_head  = tx_mem[tx_rp[AW-1:0]];

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp[AW-1:0]] <= reg_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0;
      tx_rp <= '0;
    end else if (tx_clr) begin
      tx_wp <= '0;
      tx_rp <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
    end

  logic [7:0]  rx_mem [DEPTH];
  logic [AW:0] rx_wp, rx_rp;
  logic [7:0]  rx_cur;
  logic        rx_ovf_q;

  assign rx_empty = rx_wp == rx_rp;
  assign rx_full  = (rx_wp - rx_rp) == FULL_CNT;
  assign rx_ovf   = rx_ovf_q;

  always_ff @(posedge clk)
    if (rx_push && !rx_full) rx_mem[rx_wp[AW-1:0]] <= rx_cur;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp    <= '0;
      rx_rp    <= '0;
      rx_ovf_q <= 1'b0;
    end else if (rx_clr) begin
      rx_wp    <= '0;
      rx_rp    <= '0;
      rx_ovf_q <= 1'b0;
    end else begin
      if (rx_push && !rx_full) rx_wp <= rx_wp + 1'b1;
      if (rx_push && rx_full)  rx_ovf_q <= 1'b1;
      if (rx_pop)              rx_rp <= rx_rp + 1'b1;
    end

  always_comb begin
    case (reg_addr)
      4'h4:    reg_rdata = {24'h0, rx_mem[rx_rp[AW-1:0]]};
      4'h8:    reg_rdata = ctl_q;
      default: reg_rdata = '0;
    endcase
  end

  state_t        st_q;
  logic [CW-1:0] div_q;
  logic [3:0]    edge_q;
  logic          gap_q, sclk_q, mosi_q;
  logic [7:0]    txb_q, rxb_q;
  logic          tick, start, lead, last_edge, sample_now, cont, cs_act;
  logic [2:0]    bi;

  function automatic logic pick(input logic [7:0] b, input logic [2:0] i, input logic lf);
    return lf ? b[i] : b[3'd7 - i];
  endfunction

  assign tick       = st_q != S_IDLE && div_q == CW'(HALF_DIV - 1);
  assign start      = st_q == S_IDLE && en && master && !tx_empty;
  assign lead       = !edge_q[0];
  assign bi         = edge_q[3:1];
  assign last_edge  = tick && st_q == S_XFER && edge_q == 4'd15;
  assign sample_now = tick && st_q == S_XFER && (lead != cpha);
  assign cont       = !tx_empty && !cs_rel && en && master;
  assign tx_pop     = start || (last_edge && cont);
  assign rx_push    = last_edge;
  assign cs_act     = st_q == S_XFER || st_q == S_TAIL;

  always_comb begin
    rx_cur = rxb_q;
    if (sample_now) rx_cur[lsb ? bi : 3'd7 - bi] = miso;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          div_q <= '0;
    else if (st_q == S_IDLE || tick)     div_q <= '0;
    else                                 div_q <= div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q   <= S_IDLE;
      edge_q <= '0;
      gap_q  <= 1'b0;
      sclk_q <= 1'b1;
      mosi_q <= 1'b0;
      txb_q  <= '0;
      rxb_q  <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          sclk_q <= cpol;
          if (start) begin
            st_q   <= S_XFER;
            txb_q  <= tx_head;
            rxb_q  <= '0;
            edge_q <= '0;
            if (!cpha) mosi_q <= pick(tx_head, 3'd0, lsb);
          end
        end
        S_XFER: if (tick) begin
          sclk_q <= ~sclk_q;
          edge_q <= edge_q + 1'b1;
          rxb_q  <= rx_cur;
          if (lead && cpha) mosi_q <= pick(txb_q, bi, lsb);
          if (!lead && !cpha && edge_q != 4'd15) mosi_q <= pick(txb_q, 3'(bi + 3'd1), lsb);
          if (edge_q == 4'd15) begin
            if (cont) begin
              txb_q <= tx_head;
              rxb_q <= '0;
              if (!cpha) mosi_q <= pick(tx_head, 3'd0, lsb);
            end else begin
              st_q <= S_TAIL;
            end
          end
        end
        S_TAIL: if (tick) begin
          st_q  <= S_GAP;
          gap_q <= 1'b0;
        end
        default: if (tick) begin
          if (gap_q) st_q <= S_IDLE;
          else       gap_q <= 1'b1;
        end
      endcase
    end

  assign sclk = sclk_q;
  assign mosi = mosi_q;
  assign cs   = cs_act ^ cs_pol;

endmodule

// File: rtl/spi_master_ctl_chk.sv
module spi_master_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic cpol,
  input logic cs_act,
  input logic tx_empty,
  input logic tx_full,
  input logic rx_empty,
  input logic rx_full,
  input logic rx_ovf,
  input logic rx_clr
);

  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && $stable(cpol)) |-> sclk == cpol);

  p_cs_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_act) |-> $past(!tx_empty));

  p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_act) |=> !cs_act);

  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf && !rx_clr) |=> rx_ovf);

  p_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty) && !(rx_full && rx_empty));

endmodule

bind spi_master_ctl spi_master_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cpol(cpol), .cs_act(cs_act),
  .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty),
  .rx_full(rx_full), .rx_ovf(rx_ovf), .rx_clr(rx_clr)
);

// File: tb/test_spi_master_ctl.sv
module test_spi_master_ctl;
  localparam int HALF  = 4;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic sclk, mosi, miso, cs;
  logic tx_empty, tx_full, rx_empty, rx_full, rx_ovf;

  int n_chk = 0, n_fail = 0, cyc = 0;

  spi_master_ctl #(.HALF_DIV(HALF), .DEPTH(DEPTH)) i_spi_master_ctl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs(cs),
    .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty),
    .rx_full(rx_full), .rx_ovf(rx_ovf));

  always #10 clk = ~clk;

  // slave model state
  logic b_cpol = 1'b1, b_cpha = 1'b1, b_cspol = 1'b1;
  logic [7:0] pat [16];
  logic [7:0] got [16];
  logic [7:0] sh = '0;
  int mbits = 0, nsamp = 0;
  logic act_b;
  assign act_b = (cs == ~b_cspol);

  always @(sclk) begin
    if (act_b) begin
      if (sclk == ~(b_cpol ^ b_cpha)) begin
        sh = {sh[6:0], mosi};
        nsamp++;
        if (nsamp % 8 == 0 && nsamp <= 128) got[nsamp/8 - 1] = sh;
      end else begin
        mbits++;
      end
    end
  end

  always_comb begin
    int idx;
    idx = b_cpha ? mbits - 1 : mbits;
    if (idx < 0) idx = 0;
    miso = pat[(idx / 8) % 16][7 - (idx % 8)];
  end

  // chip-select monitor
  logic prev_act = 1'b0, first_mosi = 1'b0;
  int rel_cnt = 0, run = 0, min_gap = 1000000, n_start = 0;
  always @(negedge clk) begin
    if (prev_act && !act_b) rel_cnt++;
    if (!act_b) run++;
    else begin
      if (!prev_act) begin
        if (n_start == 0) first_mosi = mosi;
        else if (run < min_gap) min_gap = run;
        n_start++;
      end
      run = 0;
    end
    prev_act = act_b;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run exceeded %0d cycles (expected completion)", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rev(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_ctl(output logic [31:0] d);
    @(negedge clk);
    reg_addr = 4'h8; #1;
    d = reg_rdata;
  endtask

  task automatic rd_rx(output logic [7:0] d);
    @(negedge clk);
    reg_addr = 4'h4; #1;
    d = reg_rdata[7:0];
    reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  function automatic logic [31:0] cfgw(input logic e, input logic m, input logic ph,
                                       input logic po, input logic sp, input logic lf,
                                       input logic rl);
    return {24'h0, rl, lf, 1'b0, sp, po, ph, m, e};
  endfunction

  task automatic mon_clear();
    repeat (4) @(negedge clk);
    mbits = 0; nsamp = 0; rel_cnt = 0; n_start = 0; min_gap = 1000000; run = 0;
    for (int k = 0; k < 16; k++) got[k] = 8'h00;
  endtask

  task automatic wait_done();
    int guard;
    guard = 0;
    while (!tx_empty && guard < 20000) begin @(negedge clk); guard++; end
    repeat (24*HALF + 8) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd_ctl(d);
    check("R1 ctl reset", d, 32'h0012_001C);
    check("R1 cs idle", cs, 1'b1);
    check("R1 sclk idle", sclk, 1'b1);
    check("R1 flags", {tx_empty, tx_full, rx_empty, rx_full, rx_ovf}, 5'b10100);
  endtask

  task automatic t_mode(input logic po, input logic ph, input logic sp,
                        input logic lf, input logic rl, input int n);
    logic [7:0] tv [8];
    logic [7:0] r;
    b_cpol = po; b_cpha = ph; b_cspol = sp;
    wr(4'h8, cfgw(1'b1, 1'b1, ph, po, sp, lf, rl));
    mon_clear();
    for (int k = 0; k < 16; k++) pat[k] = 8'h5A ^ 8'(k * 29);
    for (int k = 0; k < n; k++) tv[k] = 8'hC3 ^ 8'(k * 53 + 7);
    for (int k = 0; k < n; k++) wr(4'h0, {24'h0, tv[k]});
    wait_done();
    check("R3/R4 bits clocked", nsamp, 8*n);
    for (int k = 0; k < n; k++)
      check("R5 mosi byte order", got[k], lf ? rev(tv[k]) : tv[k]);
    for (int k = 0; k < n; k++) begin
      rd_rx(r);
      check(ph ? "R4 miso capture" : "R3 miso capture", r, lf ? rev(pat[k]) : pat[k]);
    end
    check("R6 cs idle level", cs, sp);
    check("R2 sclk idle level", sclk, po);
    if (rl) begin
      check("R8 releases per byte", rel_cnt, n);
      check("R8 min gap ok", min_gap >= 2*HALF, 1'b1);
    end else begin
      check("R7 single release", rel_cnt, 1);
    end
    if (!ph) check("R3 first bit before edge", first_mosi, lf ? tv[0][0] : tv[0][7]);
  endtask

  task automatic t_enable_txreset();
    logic [31:0] d;
    b_cpol = 1'b0; b_cpha = 1'b0; b_cspol = 1'b1;
    wr(4'h8, cfgw(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
    mon_clear();
    wr(4'h0, 32'hA7);
    repeat (40*HALF) @(negedge clk);
    check("R13 no start without enable", {tx_empty, cs, 32'(nsamp)}, {1'b0, 1'b1, 32'd0});
    wr(4'h8, cfgw(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
    repeat (40*HALF) @(negedge clk);
    check("R13 no start without master", {tx_empty, cs, 32'(nsamp)}, {1'b0, 1'b1, 32'd0});
    wr(4'h8, cfgw(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0) | 32'h100);
    check("R9 tx queue emptied", tx_empty, 1'b1);
    rd_ctl(d);
    check("R9 reset bit reads 0", d[9:8], 2'b00);
    wr(4'h8, cfgw(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
    repeat (40*HALF) @(negedge clk);
    check("R9 nothing sent after tx reset", nsamp, 0);
  endtask

  task automatic t_full_ovf();
    logic [7:0] r;
    logic [31:0] d;
    b_cpol = 1'b0; b_cpha = 1'b0; b_cspol = 1'b1;
    wr(4'h8, cfgw(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
    mon_clear();
    for (int k = 0; k < 16; k++) pat[k] = 8'h11 * 8'(k + 1);
    for (int k = 0; k < DEPTH + 2; k++) wr(4'h0, 32'(8'h40 + k));
    check("R12 tx full", tx_full, 1'b1);
    wr(4'h8, cfgw(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
    wait_done();
    check("R12 extra writes dropped", nsamp, 8*DEPTH);
    check("R12 last byte sent", got[DEPTH-1], 8'(8'h40 + DEPTH - 1));
    check("R11 rx full, no ovf yet", {rx_full, rx_ovf}, 2'b10);
    wr(4'h0, 32'hEE);
    wait_done();
    check("R11 ovf set", rx_ovf, 1'b1);
    repeat (20) @(negedge clk);
    check("R11 ovf sticky", rx_ovf, 1'b1);
    rd_rx(r);
    check("R11 stored data kept", r, pat[0]);
    wr(4'h8, cfgw(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0) | 32'h200);
    check("R10 rx emptied, ovf cleared", {rx_empty, rx_ovf}, 2'b10);
    rd_ctl(d);
    check("R10 reset bit reads 0", d[9:8], 2'b00);
  endtask

  initial begin
    for (int k = 0; k < 16; k++) begin pat[k] = 8'h00; got[k] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_mode(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3);
    t_mode(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 3);
    t_mode(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2);
    t_mode(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4);
    t_enable_txreset();
    t_full_ovf();
    summary();
    $finish;
  end
endmodule